// File: doc/BRIEF.md
# Serial Multiply Sequencer

This block turns a bit-serial carry-save multiplier core into a word-level unsigned multiplier with a start/done handshake. The multiplicand is held in parallel across the core's cells. The multiplier is consumed one bit per cycle, least significant bit first. The core produces one product bit per cycle, and a result register collects those bits into a full-width product.

A start pulse, sampled while the block is idle, captures both operands. It clears the core's partial-sum and carry state and starts a fixed run of 2*N shift cycles. Over the first N cycles the multiplier bits leave the operand register, and zeros follow them for the remaining N cycles. Those zero cycles let the core flush its stored carries into the upper half of the product. When the run completes, done rises and stays high, with the product stable, until the next accepted start.

Start, done and the operand and product buses are plain control and data pins, not a valid/ready stream. There is no back-pressure. A start that arrives while a run is in progress is dropped, and the caller should wait for done before issuing another start. The product bus is meaningful only while done is high.

Top module: `mulseq_top`

## Requirements
- R1: While reset is held and after its release, done is 0 and product is 0 until a start is accepted.
- R2: When done is high, product equals the unsigned product of the multiplicand and multiplier captured at the accepted start. This includes the corners 0, 1 and all-ones operands.
- R3: Done becomes 1 exactly after the 2*N-th rising edge that follows the edge accepting start (64 edges for N=32). It stays 0 after each of the edges before that.
- R4: Once high, done and product hold their values for as long as start stays low.
- R5: A start asserted while a run is in progress is ignored. It changes neither the completion cycle nor the product.
- R6: A start asserted while the block is idle, including while done is high, is accepted. Done is 0 after that accepting edge.
- R7: The operands are sampled only at the accepting edge. Changes on the operand inputs during the run have no effect on the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication with the current operands |
| multiplicand | input | N (32) | Parallel operand held across the core cells |
| multiplier | input | N (32) | Operand fed serially, LSB first |
| product | output | 2N (64) | Full unsigned product, valid while done is 1 |
| done | output | 1 | Run complete; held until the next accepted start |

## Verification
The bench builds the block with the default N=32, so that the 64-cycle run, the zero-fill phase and the counter wrap are exercised at their real sizes. Directed operands at zero, one and all-ones drive a carry through every one of the 32 cells and into the top product bit. Seeded random operand pairs cover the general case. The same runs inject a start in the middle of a run and scramble the operand inputs after capture, and the bench checks both against a product computed in the bench.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;
  parameter int unsigned MULSEQ_DEF_N = 32;

  function automatic int unsigned mulseq_cnt_w(input int unsigned prod_w);
    return $clog2(prod_w) + 1;
  endfunction
endpackage

// File: rtl/mulseq_shreg.sv
module mulseq_shreg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift) begin
      q <= {ser_in, q[W-1:1]};
    end
  end
endmodule

// File: rtl/mulseq_cell.sv
module mulseq_cell #(
  parameter bit LSB_CELL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  input  logic x_i,
  input  logic y_i,
  input  logic sum_i,
  output logic sum_o
);
  logic pp;
  logic s_nxt;
  logic c_nxt;
  logic c_q;

  assign pp = x_i & y_i;
  assign {c_nxt, s_nxt} = {1'b0, pp} + {1'b0, sum_i} + {1'b0, c_q};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c_q <= 1'b0;
    end else if (en) begin
      c_q <= c_nxt;
    end
  end

  generate
    if (LSB_CELL) begin : g_out_comb
      assign sum_o = s_nxt;
    end else begin : g_out_reg
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst || clr) begin
          s_q <= 1'b0;
        end else if (en) begin
          s_q <= s_nxt;
        end
      end
      assign sum_o = s_q;
    end
  endgenerate
endmodule

// File: rtl/mulseq_core.sv
module mulseq_core #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [N-1:0] x,
  input  logic         y_bit,
  output logic         p_bit
);
  logic [N:0] sum_chain;

  assign sum_chain[N] = 1'b0;

  for (genvar j = 0; j < N; j++) begin : g_cell
    mulseq_cell #(.LSB_CELL(j == 0)) u_cell (
      .clk  (clk),
      .rst  (rst),
      .clr  (clr),
      .en   (en),
      .x_i  (x[j]),
      .y_i  (y_bit),
      .sum_i(sum_chain[j+1]),
      .sum_o(sum_chain[j])
    );
  end

  assign p_bit = sum_chain[0];

  // R2: a zero multiplier bit on a freshly cleared core yields a zero product bit
  assert_zero_after_clear_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!y_bit && en) |-> !p_bit);
endmodule

// File: rtl/mulseq_ctrl.sv
module mulseq_ctrl #(
  parameter int unsigned RUN = 64,
  parameter int unsigned CW  = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic accept,
  output logic busy,
  output logic done
);
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  logic [CW-1:0] cnt;

  assign accept = start & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      done <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        done <= 1'b1;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= LAST);

  assert_done_timing_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy) && ($past(cnt) == LAST));

  assert_done_hold_R4: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> done);

  assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (rst)
    busy && start && (cnt != LAST) |=> busy && (cnt == $past(cnt) + 1'b1));

  assert_idle_start_accepted_R6: assert property (@(posedge clk) disable iff (rst)
    !busy && start |=> busy && !done && (cnt == '0));

  assert_not_both_R3: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
endmodule

// File: rtl/mulseq_top.sv
module mulseq_top #(
  parameter int unsigned N = mulseq_pkg::MULSEQ_DEF_N
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic [2*N-1:0] product,
  output logic           done
);
  localparam int unsigned PW = 2 * N;
  localparam int unsigned CW = mulseq_pkg::mulseq_cnt_w(PW);

  logic         accept;
  logic         busy;
  logic [N-1:0] mc_q;
  logic [N-1:0] mp_q;
  logic         p_bit;

  mulseq_ctrl #(.RUN(PW), .CW(CW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .accept(accept),
    .busy  (busy),
    .done  (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mc_q <= '0;
    end else if (accept) begin
      mc_q <= multiplicand;
    end
  end

  mulseq_shreg #(.W(N)) u_mp (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .load_val(multiplier),
    .shift   (busy),
    .ser_in  (1'b0),
    .q       (mp_q)
  );

  mulseq_core #(.N(N)) u_core (
    .clk  (clk),
    .rst  (rst),
    .clr  (accept),
    .en   (busy),
    .x    (mc_q),
    .y_bit(mp_q[0]),
    .p_bit(p_bit)
  );

  mulseq_shreg #(.W(PW)) u_res (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .load_val('0),
    .shift   (busy),
    .ser_in  (p_bit),
    .q       (product)
  );

  assert_product_hold_R4: assert property (@(posedge clk) disable iff (rst)
    done && !start |=> $stable(product));

  assert_operand_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mc_q));

  assert_idle_no_shift_R1: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(mp_q));
endmodule

// File: tb/tb_mulseq_top.sv
module tb_mulseq_top;
  localparam int unsigned N  = 32;
  localparam int unsigned PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  multiplicand = '0;
  logic [N-1:0]  multiplier = '0;
  logic [PW-1:0] product;
  logic          done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  mulseq_top #(.N(N)) dut (
    .clk(clk), .rst(rst), .start(start),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .product(product), .done(done)
  );

  always #10 clk = ~clk;

  function automatic logic [PW-1:0] ref_mul(input logic [N-1:0] a, input logic [N-1:0] b);
    logic [PW-1:0] wa;
    logic [PW-1:0] wb;
    wa = {{N{1'b0}}, a};
    wb = {{N{1'b0}}, b};
    return wa * wb;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One run: inject_at > 0 pulses a spurious start at that cycle (R5);
  // scramble drives random operand inputs after capture (R7).
  task automatic run_mul(input logic [N-1:0] a, input logic [N-1:0] b,
                         input int inject_at, input bit scramble);
    logic [PW-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    multiplicand = a;
    multiplier   = b;
    start        = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 done low after accepting edge", {63'd0, done}, 64'd0);
    if (scramble) begin
      multiplicand = $urandom;
      multiplier   = $urandom;
    end
    for (int k = 1; k < PW; k++) begin
      if (k == inject_at) begin
        start = 1'b1;
        multiplicand = $urandom;
        multiplier   = $urandom;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R3 done low before final edge", {63'd0, done}, 64'd0);
    @(negedge clk);
    check("R3 done high after final edge", {63'd0, done}, 64'd1);
    if (inject_at > 0)
      check("R5 product with ignored start", product, exp);
    else if (scramble)
      check("R7 product with scrambled inputs", product, exp);
    else
      check("R2 product", product, exp);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic [PW-1:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 done in reset", {63'd0, done}, 64'd0);
    check("R1 product in reset", product, 64'd0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 done idle after reset", {63'd0, done}, 64'd0);
    check("R1 product idle after reset", product, 64'd0);

    run_mul(32'd0, 32'hFFFF_FFFF, 0, 1'b0);
    run_mul(32'hFFFF_FFFF, 32'd0, 0, 1'b0);
    run_mul(32'd1, 32'd1, 0, 1'b0);
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0);
    run_mul(32'h8000_0000, 32'h8000_0000, 0, 1'b0);
    run_mul(32'd3, 32'd10, 0, 1'b0);

    held = product;
    repeat (4) @(negedge clk);
    check("R4 done held", {63'd0, done}, 64'd1);
    check("R4 product held", product, held);

    run_mul(32'h1234_5678, 32'h9ABC_DEF0, 10, 1'b0);
    run_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF, 63, 1'b0);
    run_mul(32'hDEAD_BEEF, 32'h0BAD_F00D, 0, 1'b1);

    for (int i = 0; i < 24; i++) begin
      logic [N-1:0] ra;
      logic [N-1:0] rb;
      ra = $urandom;
      rb = $urandom;
      run_mul(ra, rb, (i % 3 == 0) ? int'($urandom_range(62, 1)) : 0, (i % 2) == 1);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule